// File: doc/BRIEF.md
# Locked Index/Data Configuration Port

This block is the front end of a configuration space that is reached through two byte-wide I/O addresses. The lower address holds the index register and also takes the unlock and lock keys. The address one above it is the data port. After reset the space is sealed. Software opens it by writing the enter key byte 0x87 twice in a row to the index address, and seals it again by writing 0xAA there. While the space is open, a byte written to the index address selects a register, and reads and writes at the data address reach that register.

A small set of global registers is held in the port itself. These are a logical device number, a read-only identifier and an activate bit for each device. Registers above the activate index live in the logical devices. The port reaches them through a register-file interface. That interface has a shared address and write byte, a write strobe for each device, and a separate read-data bus from each device, which the logical device number selects between. A strap input chooses which of two base addresses the port answers at.

Top module: `lcfg_port`

## Requirements
- R1: After reset the port is sealed, the selected index is 0x00, the logical device number is 0x00, every activate output is 0 and no device write strobe is raised.
- R2: The index port sits at the base address and the data port at base plus one. The base is 0x2E when `base_sel` is 0 and 0x4E when it is 1. Any other address reads 0xFF and a write to it changes nothing.
- R3: Two index-port writes of 0x87 with no other index-port write between them open the space. An index-port write of any other byte after the first 0x87 returns the sequence to its start.
- R4: While the space is open, an index-port write of 0xAA seals it and leaves the index unchanged. Any other byte, 0x87 included, becomes the selected index.
- R5: While the space is sealed, both ports read 0xFF and a data-port write changes no register and raises no strobe.
- R6: Index 0x07 holds the logical device number. It can be written and read back through the data port.
- R7: Index 0x20 reads the identifier parameter (default 0xA7), and a data-port write to it has no effect.
- R8: Index 0x30 holds the activate bit of the selected device in bit 0 and reads back with bits 7..1 as zero. Each device's bit drives its `dev_active` output.
- R9: For indices 0x31 to 0xFF, a data-port write raises exactly the strobe of the selected device, in the same cycle, with `dev_addr` equal to the index and `dev_wdata` equal to the byte. A data-port read returns that device's read-data byte.
- R10: When the logical device number is not below `NUM_DEV`, index 0x30 and indices above it read 0xFF, writes there raise no strobe and change no activate bit.
- R11: Global indices below 0x30 other than 0x07 and 0x20 read 0x00, and writes to them have no effect.
- R12: While the space is open, a read of the index port returns the selected index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Base address strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write qualifier for the current access |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte for the addressed port |
| dev_addr | output | 8 | Register index presented to the devices |
| dev_wdata | output | 8 | Write byte presented to the devices |
| dev_wr | output | NUM_DEV | One write strobe for each logical device |
| dev_rdata | input | 8*NUM_DEV | Read bytes from the devices, device d in bits 8d+7..8d |
| dev_active | output | NUM_DEV | Activate bit of each logical device |

## Verification
Reads are combinational. `io_rdata` answers in the same cycle as the address, and it reflects every write that was taken at an earlier rising edge. Device strobes, `dev_addr` and `dev_wdata` are valid in the same cycle as the data-port write. Key, index, device number and activate updates take effect at the rising edge that ends the write cycle and can be seen from the next cycle. The bench changes its inputs on the falling edge and samples 1 ns before the rising edge that commits them. It updates its own model of the register state only after that edge, so each expected value is computed from the state the design holds in the sampled cycle.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_ENTER  = 8'h87;
  localparam logic [7:0] KEY_EXIT   = 8'hAA;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_ACTIVE = 8'h30;
  localparam logic [7:0] BYTE_FLOAT = 8'hFF;

endpackage

// File: rtl/lcfg_keyfsm.sv
module lcfg_keyfsm
  import lcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       load_idx
);

  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      case (st_q)
        KS_LOCKED: if (wdata == KEY_ENTER) st_d = KS_HALF;
        KS_HALF:   st_d = (wdata == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (wdata == KEY_EXIT) st_d = KS_LOCKED;
        default:   st_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_LOCKED;
    else        st_q <= st_d;
  end

  assign cfg_open = (st_q == KS_OPEN);
  assign load_idx = idx_wr && cfg_open && (wdata != KEY_EXIT);

  AST_OPEN_NEEDS_TWO_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> ($past(idx_wr && wdata == KEY_ENTER) && $past(st_q == KS_HALF))); // R3

  AST_BROKEN_KEY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && st_q == KS_HALF && wdata != KEY_ENTER) |=> (st_q == KS_LOCKED)); // R3

  AST_EXIT_KEY_SEALS: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && cfg_open && wdata == KEY_EXIT) |=> !cfg_open); // R4

endmodule

// File: rtl/lcfg_decode.sv
module lcfg_decode #(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_LO = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_HI = 16'h004E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              load_idx,
  input  logic [7:0]        wdata,
  output logic              idx_hit,
  output logic              dat_hit,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic [7:0]        cur_idx
);

  logic [ADDR_W-1:0] base;
  logic [7:0]        idx_q, idx_d;

  assign base    = base_sel ? BASE_HI : BASE_LO;
  assign idx_hit = (io_addr == base);
  assign dat_hit = (io_addr == ADDR_W'(base + 1'b1));
  assign idx_wr  = io_wr && idx_hit;
  assign dat_wr  = io_wr && dat_hit;

  always_comb begin
    idx_d = idx_q;
    if (load_idx) idx_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= 8'h00;
    else        idx_q <= idx_d;
  end

  assign cur_idx = idx_q;

endmodule

// File: rtl/lcfg_bank.sv
module lcfg_bank
  import lcfg_pkg::*;
#(
  parameter int         NUM_DEV = 4,
  parameter logic [7:0] CHIP_ID = 8'hA7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_open,
  input  logic                 dat_wr,
  input  logic [7:0]           cur_idx,
  input  logic [7:0]           wdata,
  input  logic [8*NUM_DEV-1:0] dev_rdata,
  output logic [NUM_DEV-1:0]   dev_wr,
  output logic [NUM_DEV-1:0]   dev_active,
  output logic [7:0]           dat_rdata
);

  localparam int         DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] NDEV8 = 8'(NUM_DEV);

  logic [7:0]         ldn_q, ldn_d;
  logic [NUM_DEV-1:0] act_q, act_d;
  logic               wr_ok, sel_ok, sel_act;
  logic [DEV_W-1:0]   dsel;
  logic [7:0]         sel_rd;

  assign wr_ok  = cfg_open && dat_wr;
  assign sel_ok = (ldn_q < NDEV8);
  assign dsel   = ldn_q[DEV_W-1:0];

  always_comb begin
    ldn_d = ldn_q;
    if (wr_ok && cur_idx == IDX_LDN) ldn_d = wdata;
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic hit;
    assign hit       = wr_ok && sel_ok && (dsel == DEV_W'(g));
    assign act_d[g]  = (hit && cur_idx == IDX_ACTIVE) ? wdata[0] : act_q[g];
    assign dev_wr[g] = hit && (cur_idx > IDX_ACTIVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn_q <= 8'h00;
      act_q <= '0;
    end else begin
      ldn_q <= ldn_d;
      act_q <= act_d;
    end
  end

  always_comb begin
    sel_act = 1'b0;
    sel_rd  = BYTE_FLOAT;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (dsel == DEV_W'(d)) begin
        sel_act = act_q[d];
        sel_rd  = dev_rdata[8*d +: 8];
      end
    end
  end

  always_comb begin
    if (cur_idx == IDX_LDN)           dat_rdata = ldn_q;
    else if (cur_idx == IDX_CHIPID)   dat_rdata = CHIP_ID;
    else if (cur_idx == IDX_ACTIVE)   dat_rdata = sel_ok ? {7'b0, sel_act} : BYTE_FLOAT;
    else if (cur_idx > IDX_ACTIVE)    dat_rdata = sel_ok ? sel_rd : BYTE_FLOAT;
    else                              dat_rdata = 8'h00;
  end

  assign dev_active = act_q;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_wr)); // R9

  AST_LDN_HELD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr != '0) |=> $stable(ldn_q)); // R9

endmodule

// File: rtl/lcfg_port.sv
module lcfg_port
  import lcfg_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_LO = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_HI = 16'h004E,
  parameter int                NUM_DEV = 4,
  parameter logic [7:0]        CHIP_ID = 8'hA7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 base_sel,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_wr,
  input  logic [7:0]           io_wdata,
  output logic [7:0]           io_rdata,
  output logic [7:0]           dev_addr,
  output logic [7:0]           dev_wdata,
  output logic [NUM_DEV-1:0]   dev_wr,
  input  logic [8*NUM_DEV-1:0] dev_rdata,
  output logic [NUM_DEV-1:0]   dev_active
);

  logic       rst_meta_q, rst_sync_q, rst_i_n;
  logic       idx_hit, dat_hit, idx_wr, dat_wr;
  logic       cfg_open, load_idx;
  logic [7:0] cur_idx, dat_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_i_n = rst_sync_q;

  lcfg_decode #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_decode (
    .clk(clk), .rst_n(rst_i_n), .base_sel(base_sel), .io_addr(io_addr),
    .io_wr(io_wr), .load_idx(load_idx), .wdata(io_wdata),
    .idx_hit(idx_hit), .dat_hit(dat_hit), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .cur_idx(cur_idx)
  );

  lcfg_keyfsm u_keyfsm (
    .clk(clk), .rst_n(rst_i_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .cfg_open(cfg_open), .load_idx(load_idx)
  );

  lcfg_bank #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .cfg_open(cfg_open), .dat_wr(dat_wr),
    .cur_idx(cur_idx), .wdata(io_wdata), .dev_rdata(dev_rdata),
    .dev_wr(dev_wr), .dev_active(dev_active), .dat_rdata(dat_rdata)
  );

  always_comb begin
    if (!cfg_open)    io_rdata = BYTE_FLOAT;
    else if (idx_hit) io_rdata = cur_idx;
    else if (dat_hit) io_rdata = dat_rdata;
    else              io_rdata = BYTE_FLOAT;
  end

  assign dev_addr  = cur_idx;
  assign dev_wdata = io_wdata;

  AST_SEALED_SILENT: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_open |-> (dev_wr == '0 && io_rdata == BYTE_FLOAT)); // R5

  AST_ACTIVE_FROZEN_SEALED: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_open |=> $stable(dev_active)); // R8

  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(cfg_open && io_wr && idx_hit) |=> $stable(cur_idx)); // R4

endmodule

// File: tb/lcfg_port_tb_top.sv
`timescale 1ns/1ps
module lcfg_port_tb_top;

  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          base_sel;
  logic [15:0]   io_addr;
  logic          io_wr;
  logic [7:0]    io_wdata;
  logic [7:0]    io_rdata, dev_addr, dev_wdata;
  logic [ND-1:0] dev_wr, dev_active;
  logic [8*ND-1:0] dev_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  int         m_st;
  logic [7:0] m_idx, m_ldn;
  logic [ND-1:0] m_act;
  logic [7:0] dmem [ND][256];

  always #2 clk = ~clk;

  lcfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_wr(dev_wr),
    .dev_rdata(dev_rdata), .dev_active(dev_active)
  );

  // device register files behind the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < ND; d++)
        for (int a = 0; a < 256; a++) dmem[d][a] <= 8'(d * 37 + a * 5 + 1);
    end else begin
      for (int d = 0; d < ND; d++)
        if (dev_wr[d]) dmem[d][dev_addr] <= dev_wdata;
    end
  end

  always_comb
    for (int d = 0; d < ND; d++) dev_rdata[8*d +: 8] = dmem[d][dev_addr];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] bse();
    return base_sel ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    if (m_st != 2) return 8'hFF;
    if (a == bse()) return m_idx;
    if (a != bse() + 16'd1) return 8'hFF;
    if (m_idx == 8'h07) return m_ldn;
    if (m_idx == 8'h20) return 8'hA7;
    if (m_idx == 8'h30) return (m_ldn < ND) ? {7'b0, m_act[m_ldn[1:0]]} : 8'hFF;
    if (m_idx > 8'h30)  return (m_ldn < ND) ? dmem[m_ldn[1:0]][m_idx] : 8'hFF;
    return 8'h00;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [ND-1:0] es;
    @(negedge clk);
    io_addr = a; io_wr = 1'b1; io_wdata = d;
    #1;
    es = '0;
    if (a == bse() + 16'd1 && m_st == 2 && m_idx > 8'h30 && m_ldn < ND)
      es[m_ldn[1:0]] = 1'b1;
    chk("R9/R10/R5 strobe", 32'(dev_wr), 32'(es));
    if (es != '0) begin
      chk("R9 dev_addr", 32'(dev_addr), 32'(m_idx));
      chk("R9 dev_wdata", 32'(dev_wdata), 32'(d));
    end
    @(posedge clk);
    if (a == bse()) begin
      case (m_st)
        0: if (d == 8'h87) m_st = 1;
        1: m_st = (d == 8'h87) ? 2 : 0;
        default: if (d == 8'hAA) m_st = 0; else m_idx = d;
      endcase
    end else if (a == bse() + 16'd1 && m_st == 2) begin
      if (m_idx == 8'h07) m_ldn = d;
      else if (m_idx == 8'h30 && m_ldn < ND) m_act[m_ldn[1:0]] = d[0];
    end
    #1 io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string r);
    @(negedge clk);
    io_addr = a; io_wr = 1'b0;
    #1;
    chk(r, 32'(io_rdata), 32'(exp_rd(a)));
    chk("R8 dev_active", 32'(dev_active), 32'(m_act));
  endtask

  task automatic unlock();
    wr(bse(), 8'h87);
    wr(bse(), 8'h87);
  endtask

  task automatic sel(input logic [7:0] i);
    wr(bse(), i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    process::self().srandom(32'd5173);
    rst_n = 1'b0; base_sel = 1'b0; io_addr = '0; io_wr = 1'b0; io_wdata = '0;
    m_st = 0; m_idx = 8'h00; m_ldn = 8'h00; m_act = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    chk("R1 dev_wr", 32'(dev_wr), 0);
    chk("R1 dev_active", 32'(dev_active), 0);
    rd(16'h002E, "R1 sealed index read");
    // R5 sealed data port
    rd(16'h002F, "R5 sealed data read");
    wr(16'h002F, 8'h3C);
    // R3 broken key restarts
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h11); wr(16'h002E, 8'h87);
    rd(16'h002F, "R3 broken key keeps sealed");
    wr(16'h002E, 8'h87);
    rd(16'h002E, "R1 R12 index after reset");
    sel(8'h07);
    rd(16'h002F, "R1 R5 ldn untouched while sealed");
    // R6
    wr(16'h002F, 8'h03);
    rd(16'h002F, "R6 ldn readback");
    // R7
    sel(8'h20);
    rd(16'h002F, "R7 chip id");
    wr(16'h002F, 8'h55);
    rd(16'h002F, "R7 chip id after write");
    // R8
    sel(8'h07); wr(16'h002F, 8'h02);
    sel(8'h30); wr(16'h002F, 8'hFF);
    rd(16'h002F, "R8 activate readback");
    // R9
    sel(8'h45); wr(16'h002F, 8'h9C);
    rd(16'h002F, "R9 forwarded readback");
    sel(8'h31); rd(16'h002F, "R9 lowest forwarded index");
    // R10
    sel(8'h07); wr(16'h002F, 8'h09);
    sel(8'h30); wr(16'h002F, 8'h01);
    rd(16'h002F, "R10 activate out of range");
    sel(8'h50); wr(16'h002F, 8'h44);
    rd(16'h002F, "R10 forwarded out of range");
    // R11
    sel(8'h10); wr(16'h002F, 8'h66);
    rd(16'h002F, "R11 unused global index");
    // R4 key byte as index, then exit
    sel(8'h87);
    rd(16'h002E, "R4 R12 enter byte as index");
    wr(16'h002E, 8'hAA);
    rd(16'h002E, "R4 exit seals");
    // R2 alternate base
    base_sel = 1'b1;
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    rd(16'h004E, "R2 old base does not unlock");
    unlock();
    rd(16'h004E, "R2 index at alternate base");
    rd(16'h002E, "R2 old base floats");
    wr(16'h002F, 8'h12);
    rd(16'h004F, "R2 data at alternate base");

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int k;
      if ($urandom_range(0, 199) == 0) base_sel = ~base_sel;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: a = bse();
        3, 4, 5, 6: a = bse() + 16'd1;
        7: a = 16'h002E + 16'($urandom_range(0, 1));
        8: a = 16'h004E + 16'($urandom_range(0, 1));
        default: a = 16'($urandom_range(0, 255));
      endcase
      k = $urandom_range(0, 11);
      case (k)
        0, 1: d = 8'h87;
        2: d = 8'hAA;
        3: d = 8'h07;
        4: d = 8'h20;
        5: d = 8'h30;
        6, 7: d = 8'($urandom_range(0, 5));
        8: d = 8'h31 + 8'($urandom_range(0, 7));
        default: d = 8'($urandom);
      endcase
      if ($urandom_range(0, 1) == 0) wr(a, d);
      else rd(a, "R2-R12 random read");
    end

    @(negedge clk);
    summary();
    $finish;
  end

endmodule